// File: doc/BRIEF.md
# Compound Sum and Increment Adder

This block takes two unsigned operands of equal width and produces two results at once: the plain sum and the sum plus one, both reduced modulo 2^N. It also produces a group generate bit and a group propagate bit for the full width. A consumer such as a rounding stage can then pick either result late, without waiting for a second carry chain.

The datapath is purely combinational and is built as a recursive tree. Each node cuts its operands into a lower part of floor(W/2) bits and an upper part holding the rest, and builds each part in the same way. Recursion ends at a leaf once the part is no wider than a threshold parameter. A leaf returns its sum, its sum plus one, a generate bit and a propagate bit. On the way back up, each node merges its two parts by choosing between the upper part's two candidate results, using the lower part's generate and propagate bits. The carry out of the top is reported only on the generate output. It is never added to the results.

Top module: `compound_adder`

## Requirements
- R1: `sum_o` equals (x_i + y_i) mod 2^WIDTH for every input pair.
- R2: `sum_p1_o` equals (x_i + y_i + 1) mod 2^WIDTH for every input pair.
- R3: `gen_o` is 1 exactly when x_i + y_i is at least 2^WIDTH, which is the carry out of the plain sum.
- R4: `prop_o` is 1 exactly when x_i XOR y_i has every bit set.
- R5: `gen_o` and `prop_o` are never 1 at the same time.
- R6: Results do not depend on the leaf threshold or on an odd width. A 13-bit instance with threshold 4, which has uneven splits and multi-bit leaves, meets R1 to R5.
- R7: When x_i + y_i equals 2^WIDTH - 1 (for example alternating patterns 0xAAAAAAAA and 0x55555555), `sum_o` is all ones, `sum_p1_o` is 0, `prop_o` is 1 and `gen_o` is 0.
- R8: Both results stay WIDTH bits wide and the carry is dropped. All ones plus one gives `sum_o` = 0, `sum_p1_o` = 1 and `gen_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | first unsigned operand |
| y_i | input | WIDTH | second unsigned operand |
| sum_o | output | WIDTH | x_i + y_i, truncated |
| sum_p1_o | output | WIDTH | x_i + y_i + 1, truncated |
| gen_o | output | 1 | carry out of x_i + y_i |
| prop_o | output | 1 | high when every bit position propagates |

## Verification
Every result is combinational, so each output is due in the same clock cycle as the operands that produce it. No result is held over to a later cycle. The bench changes the operands 2 ns after a rising edge. It compares all four outputs of both instances with a behavioural reference at the next falling edge, well after the outputs have settled and well before the next operand change.

// File: rtl/cadd_pkg.sv
`timescale 1ns/1ps
package cadd_pkg;
  // width of the lower part when a slice of w bits is cut in two
  function automatic int lo_width(input int w);
    return w / 2;
  endfunction

  // a slice becomes a leaf once it is no wider than the threshold
  function automatic bit is_leaf(input int w, input int lim);
    return (w <= lim) || (w <= 1);
  endfunction
endpackage

// File: rtl/cadd_leaf.sv
`timescale 1ns/1ps
module cadd_leaf #(
  parameter int W = 1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] s1_o,
  output logic         g_o,
  output logic         p_o
);
  generate
    if (W == 1) begin : g_bit
      logic half;
      always_comb begin
        half = a_i[0] ^ b_i[0];
        s_o  = half;
        s1_o = ~half;
        g_o  = a_i[0] & b_i[0];
        p_o  = half;
      end
    end else begin : g_vec
      localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
      logic [W:0] full;
      always_comb begin
        full = {1'b0, a_i} + {1'b0, b_i};
        s_o  = full[W-1:0];
        s1_o = a_i + b_i + ONE;
        g_o  = full[W];
        p_o  = &(a_i ^ b_i);
      end
    end
  endgenerate
endmodule

// File: rtl/cadd_merge.sv
`timescale 1ns/1ps
module cadd_merge #(
  parameter int LW = 1,
  parameter int HW = 1
) (
  input  logic [LW-1:0]    lo_s_i,
  input  logic [LW-1:0]    lo_s1_i,
  input  logic             lo_g_i,
  input  logic             lo_p_i,
  input  logic [HW-1:0]    hi_s_i,
  input  logic [HW-1:0]    hi_s1_i,
  input  logic             hi_g_i,
  input  logic             hi_p_i,
  output logic [LW+HW-1:0] s_o,
  output logic [LW+HW-1:0] s1_o,
  output logic             g_o,
  output logic             p_o
);
  logic sel_s;
  logic sel_s1;

  always_comb begin
    // carry into the upper part: plain sum needs lower generate,
    // incremented sum also takes it when the lower part propagates
    sel_s  = lo_g_i;
    sel_s1 = lo_g_i | lo_p_i;
    s_o    = {(sel_s  ? hi_s1_i : hi_s_i), lo_s_i};
    s1_o   = {(sel_s1 ? hi_s1_i : hi_s_i), lo_s1_i};
    g_o    = hi_g_i | (hi_p_i & lo_g_i);
    p_o    = hi_p_i & lo_p_i;
  end
endmodule

// File: rtl/cadd_node.sv
`timescale 1ns/1ps
module cadd_node #(
  parameter int W   = 32,
  parameter int LIM = 1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] s1_o,
  output logic         g_o,
  output logic         p_o
);
  generate
    if (cadd_pkg::is_leaf(W, LIM)) begin : g_leaf
      cadd_leaf #(.W(W)) u_leaf (
        .a_i (a_i),
        .b_i (b_i),
        .s_o (s_o),
        .s1_o(s1_o),
        .g_o (g_o),
        .p_o (p_o)
      );
    end else begin : g_split
      localparam int LW = cadd_pkg::lo_width(W);
      localparam int HW = W - LW;

      logic [LW-1:0] lo_s, lo_s1;
      logic [HW-1:0] hi_s, hi_s1;
      logic          lo_g, lo_p, hi_g, hi_p;

      cadd_node #(.W(LW), .LIM(LIM)) u_lo (
        .a_i (a_i[LW-1:0]),
        .b_i (b_i[LW-1:0]),
        .s_o (lo_s),
        .s1_o(lo_s1),
        .g_o (lo_g),
        .p_o (lo_p)
      );

      cadd_node #(.W(HW), .LIM(LIM)) u_hi (
        .a_i (a_i[W-1:LW]),
        .b_i (b_i[W-1:LW]),
        .s_o (hi_s),
        .s1_o(hi_s1),
        .g_o (hi_g),
        .p_o (hi_p)
      );

      cadd_merge #(.LW(LW), .HW(HW)) u_mrg (
        .lo_s_i (lo_s),
        .lo_s1_i(lo_s1),
        .lo_g_i (lo_g),
        .lo_p_i (lo_p),
        .hi_s_i (hi_s),
        .hi_s1_i(hi_s1),
        .hi_g_i (hi_g),
        .hi_p_i (hi_p),
        .s_o    (s_o),
        .s1_o   (s1_o),
        .g_o    (g_o),
        .p_o    (p_o)
      );
    end
  endgenerate
endmodule

// File: rtl/compound_adder.sv
`timescale 1ns/1ps
module compound_adder #(
  parameter int WIDTH       = 32,
  parameter int LOWER_LIMIT = 1
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] sum_p1_o,
  output logic             gen_o,
  output logic             prop_o
);
  cadd_node #(.W(WIDTH), .LIM(LOWER_LIMIT)) u_root (
    .a_i (x_i),
    .b_i (y_i),
    .s_o (sum_o),
    .s1_o(sum_p1_o),
    .g_o (gen_o),
    .p_o (prop_o)
  );
endmodule

// File: rtl/compound_adder_chk.sv
`timescale 1ns/1ps
module compound_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] x_i,
  input logic [WIDTH-1:0] y_i,
  input logic [WIDTH-1:0] sum_o,
  input logic [WIDTH-1:0] sum_p1_o,
  input logic             gen_o,
  input logic             prop_o
);
  logic [WIDTH:0] wide;
  logic [WIDTH:0] wide1;

  always_comb begin
    wide  = {1'b0, x_i} + {1'b0, y_i};
    wide1 = wide + {{WIDTH{1'b0}}, 1'b1};
    a_r1_sum_mod:    assert (sum_o == wide[WIDTH-1:0]);
    a_r2_inc_mod:    assert (sum_p1_o == wide1[WIDTH-1:0]);
    a_r3_gen_carry:  assert (gen_o == wide[WIDTH]);
    a_r4_prop_ones:  assert (prop_o == (wide == {1'b0, {WIDTH{1'b1}}}));
    a_r5_exclusive:  assert (!(gen_o && prop_o));
  end
endmodule

bind compound_adder compound_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .x_i     (x_i),
  .y_i     (y_i),
  .sum_o   (sum_o),
  .sum_p1_o(sum_p1_o),
  .gen_o   (gen_o),
  .prop_o  (prop_o)
);

// File: tb/compound_adder_tb_top.sv
`timescale 1ns/1ps
module compound_adder_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  logic [31:0] xa, ya, sa, sa1;
  logic        ga, pa;
  logic [12:0] xb, yb, sb, sb1;
  logic        gb, pb;

  compound_adder #(.WIDTH(32), .LOWER_LIMIT(1)) dut_i (
    .x_i(xa), .y_i(ya), .sum_o(sa), .sum_p1_o(sa1), .gen_o(ga), .prop_o(pa)
  );

  compound_adder #(.WIDTH(13), .LOWER_LIMIT(4)) dut2_i (
    .x_i(xb), .y_i(yb), .sum_o(sb), .sum_p1_o(sb1), .gen_o(gb), .prop_o(pb)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference for the 32-bit instance
  task automatic check_wide(input string tag);
    logic [32:0] s;
    logic [32:0] s1;
    s  = {1'b0, xa} + {1'b0, ya};
    s1 = s + 33'd1;
    chk({"R1 ", tag}, 64'(sa),  64'(s[31:0]));
    chk({"R2 ", tag}, 64'(sa1), 64'(s1[31:0]));
    chk({"R3 ", tag}, 64'(ga),  64'(s[32]));
    chk({"R4 ", tag}, 64'(pa),  64'((xa ^ ya) == 32'hFFFF_FFFF));
    chk({"R5 ", tag}, 64'(ga & pa), 64'd0);
  endtask

  // behavioural reference for the 13-bit, threshold-4 instance
  task automatic check_narrow(input string tag);
    logic [13:0] s;
    logic [13:0] s1;
    s  = {1'b0, xb} + {1'b0, yb};
    s1 = s + 14'd1;
    chk({"R6 sum ", tag}, 64'(sb),  64'(s[12:0]));
    chk({"R6 inc ", tag}, 64'(sb1), 64'(s1[12:0]));
    chk({"R6 gen ", tag}, 64'(gb),  64'(s[13]));
    chk({"R6 prop ", tag}, 64'(pb), 64'((xb ^ yb) == 13'h1FFF));
  endtask

  // operands change just after a rising edge, results due the same cycle
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input string tag);
    @(posedge clk);
    #2;
    xa = a;
    ya = b;
    xb = a[12:0];
    yb = b[12:0];
    @(negedge clk);
    check_wide(tag);
    check_narrow(tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    xa = '0; ya = '0; xb = '0; yb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // zero operands during reset
    chk("R1 reset sum",  64'(sa),  64'd0);
    chk("R2 reset inc",  64'(sa1), 64'd1);
    chk("R3 reset gen",  64'(ga),  64'd0);
    chk("R4 reset prop", 64'(pa),  64'd0);
    rst_n = 1'b1;

    apply(32'h0000_0000, 32'h0000_0000, "zeros");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, "ones");
    apply(32'hAAAA_AAAA, 32'h5555_5555, "alt");
    chk("R7 alt sum",  64'(sa),  64'hFFFF_FFFF);
    chk("R7 alt inc",  64'(sa1), 64'd0);
    chk("R7 alt prop", 64'(pa),  64'd1);
    chk("R7 alt gen",  64'(ga),  64'd0);
    apply(32'hFFFF_FFFF, 32'h0000_0001, "wrap");
    chk("R8 wrap sum", 64'(sa),  64'd0);
    chk("R8 wrap inc", 64'(sa1), 64'd1);
    chk("R8 wrap gen", 64'(ga),  64'd1);
    apply(32'h0000_FFFF, 32'h0000_0001, "mid carry");
    apply(32'h0000_FFFF, 32'h0000_0000, "mid prop");
    apply(32'h8000_0000, 32'h8000_0000, "msb");
    apply(32'h7FFF_FFFF, 32'h0000_0000, "low ones");
    apply(32'h5555_5555, 32'h5555_5555, "alt same");
    apply(32'h0000_0FFF, 32'h0000_1000, "narrow prop");
    for (int i = 0; i < 300; i++) begin
      apply($urandom, $urandom, "random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule